// File: doc/BRIEF.md
# Control Register Bus with Cross-Clock Handshake

This block links one CPU-side master to a row of small register slaves over a narrow control bus. The address is 10 bits and the data 32 bits. Each slave may run on its own clock, which may be faster or slower than the master's clock and need not be related to it. A transfer is a four-phase handshake. The master raises a read or a write strobe and holds it until an acknowledge comes back. The addressed slave keeps its acknowledge up until the strobe drops, and the master then waits for the acknowledge to fall before it ends the transfer.

Read data does not pass through a central multiplexer. It travels along a chain that starts at zero. Each slave forwards the word it receives unchanged, except while it is selected and acknowledging, when it substitutes its own register value. The master takes the word at the end of the chain.

The CPU issues a request with a one-cycle `req_valid` pulse. It waits for `done`, then reads `rdata` and `err`. An address that no slave decodes times out after a set number of cycles and reports an error.

Top module: `crb_bus`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rdata` are 0, and every slave register reads back as 0.
- R2: A write to slave i at address `SLV_BASE + i*2**REG_BITS + k` is returned by a later read of the same address, whichever slave clock is faster or slower than the master clock.
- R3: `req_valid` is ignored while `busy` is 1. A request raised during a transfer neither starts a second transfer nor changes any register.
- R4: A slave replaces the chain word only while it acknowledges; otherwise it forwards the word unchanged. The chain starts at zero, so a read returns only the addressed register, never a merge with other slaves.
- R5: The master holds its strobe until it sees the acknowledge, and starts no strobe while the acknowledge is high. A slave holds its acknowledge until it sees the strobe low.
- R6: With no acknowledge, the master drops its strobe after `TIMEOUT` cycles (default 256). It then finishes with `err`=1 and `rdata`=0, and no register changes.
- R7: `done` comes no earlier than two master cycles after the request is accepted.
- R8: Read and write strobes are never high together.
- R9: A write changes only the one addressed register; neighbouring registers in the same slave keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| slv_clk | input | NUM_SLV | One clock per slave |
| req_valid | input | 1 | Request pulse, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Register address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Last transfer timed out, valid from `done` until the next accept |
| rdata | output | 32 | Read result of the last transfer |

## Verification
The assertions assume that every slave is reset together with the master and that each slave clock keeps toggling. They also assume that the CPU raises `req_valid` only as a clean level sampled on the master clock. The assertions do not depend on when a request arrives during a transfer, because the master alone decides when the strobe starts. The bench keeps within these assumptions: it drives requests only on falling master edges, runs three free slave clocks at 4, 26 and 10 ns periods with differing phases, and deliberately pulses `req_valid` during a busy transfer to exercise R3.

// File: rtl/crb_pkg.sv
package crb_pkg;
   localparam int AW = 10;
   localparam int DW = 32;

   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_REQ  = 2'd1,
      M_REL  = 2'd2
   } mst_state_e;
endpackage

// File: rtl/crb_sync.sv
module crb_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   generate
      if (W < 1) begin : g_bad_w
         $error("crb_sync: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/crb_slave.sv
module crb_slave
   import crb_pkg::*;
#(
   parameter int          REG_BITS = 2,
   parameter logic [AW-1:0] BASE   = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] chain_in,
   output logic [DW-1:0] chain_out,
   output logic          ack
);
   localparam int NREG = 1 << REG_BITS;

   generate
      if (REG_BITS < 1 || REG_BITS >= AW) begin : g_bad_regbits
         $error("crb_slave: REG_BITS out of range");
      end
      if (BASE[REG_BITS-1:0] != '0) begin : g_bad_base
         $error("crb_slave: BASE not aligned to register block");
      end
   endgenerate

   logic [1:0]          stb_s;   // {read, write} after two flops
   logic                seen;
   logic                sel;
   logic [REG_BITS-1:0] idx;
   logic [DW-1:0]       regs [NREG];
   logic [DW-1:0]       rd_hold;

   // Address and data are held by the master for the whole handshake and
   // are settled long before the strobe leaves the synchronizer.
   crb_sync #(.W(2)) u_stb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rd_stb, wr_stb}),
      .q     (stb_s)
   );

   assign seen = stb_s[1] | stb_s[0];
   assign sel  = (addr[AW-1:REG_BITS] == BASE[AW-1:REG_BITS]);
   assign idx  = addr[REG_BITS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack     <= 1'b0;
         rd_hold <= '0;
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (!ack && seen && sel) begin
         ack <= 1'b1;
         if (stb_s[0]) begin
            regs[idx] <= wdata;
            rd_hold   <= wdata;
         end else begin
            rd_hold   <= regs[idx];
         end
      end else if (ack && !seen) begin
         ack <= 1'b0;
      end
   end

   // Chain segment: substitute only while acknowledging.
   assign chain_out = ack ? rd_hold : chain_in;

   a_r5_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> $past(!seen));
   a_r5_ack_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(seen && sel));
   a_r4_chain_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |-> (chain_out == chain_in));
   a_r8_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_s));
endmodule

// File: rtl/crb_master.sv
module crb_master
   import crb_pkg::*;
#(
   parameter int TIMEOUT = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] rdata,
   output logic          rd_stb,
   output logic          wr_stb,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic [DW-1:0] chain_end
);
   localparam int TW = $clog2(TIMEOUT + 1);

   generate
      if (TIMEOUT < 4) begin : g_bad_tmo
         $error("crb_master: TIMEOUT must be at least 4");
      end
   endgenerate

   mst_state_e    state;
   logic          ack_s;
   logic [TW-1:0] tmo_cnt;
   logic          is_write;

   crb_sync #(.W(1)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_ack),
      .q     (ack_s)
   );

   assign busy = (state != M_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= M_IDLE;
         rd_stb    <= 1'b0;
         wr_stb    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         is_write  <= 1'b0;
         tmo_cnt   <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            M_IDLE: begin
               if (req_valid) begin
                  bus_addr  <= req_addr;
                  bus_wdata <= req_wdata;
                  is_write  <= req_write;
                  wr_stb    <= req_write;
                  rd_stb    <= !req_write;
                  tmo_cnt   <= '0;
                  err       <= 1'b0;
                  state     <= M_REQ;
               end
            end
            M_REQ: begin
               if (ack_s) begin
                  if (!is_write) rdata <= chain_end;
                  rd_stb <= 1'b0;
                  wr_stb <= 1'b0;
                  state  <= M_REL;
               end else if (tmo_cnt == TW'(TIMEOUT - 1)) begin
                  rd_stb <= 1'b0;
                  wr_stb <= 1'b0;
                  err    <= 1'b1;
                  rdata  <= '0;
                  state  <= M_REL;
               end else begin
                  tmo_cnt <= tmo_cnt + 1'b1;
               end
            end
            M_REL: begin
               if (!ack_s) begin
                  done  <= 1'b1;
                  state <= M_IDLE;
               end
            end
            default: state <= M_IDLE;
         endcase
      end
   end

   // Checker-side cycle count since acceptance, used by the R7 property.
   logic [3:0] chk_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             chk_cyc <= '0;
      else if (!busy)         chk_cyc <= '0;
      else if (chk_cyc != '1) chk_cyc <= chk_cyc + 1'b1;
   end

   a_r8_onehot_stb: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_stb, wr_stb}));
   a_r5_no_stb_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_stb | wr_stb) |-> !ack_s);
   a_r5_stb_held: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_stb | wr_stb) |-> ($past(ack_s) || err));
   a_r7_min_two: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (chk_cyc >= 4'd2 || $past(chk_cyc) >= 4'd2));
   a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (rdata == '0));
endmodule

// File: rtl/crb_bus.sv
module crb_bus
   import crb_pkg::*;
#(
   parameter int            NUM_SLV  = 3,
   parameter int            REG_BITS = 2,
   parameter logic [AW-1:0] SLV_BASE = 10'h040,
   parameter int            TIMEOUT  = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SLV-1:0] slv_clk,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [AW-1:0]      req_addr,
   input  logic [DW-1:0]      req_wdata,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [DW-1:0]      rdata
);
   localparam int NREG = 1 << REG_BITS;

   generate
      if (NUM_SLV < 1 || (NUM_SLV * NREG) > (1 << AW)) begin : g_bad_map
         $error("crb_bus: slave map does not fit the address space");
      end
   endgenerate

   logic               rd_stb, wr_stb;
   logic [AW-1:0]      bus_addr;
   logic [DW-1:0]      bus_wdata;
   logic [NUM_SLV-1:0] ack_v;
   logic [DW-1:0]      chain [NUM_SLV+1];

   assign chain[0] = '0;

   crb_master #(.TIMEOUT(TIMEOUT)) u_mst (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .rdata     (rdata),
      .rd_stb    (rd_stb),
      .wr_stb    (wr_stb),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (|ack_v),
      .chain_end (chain[NUM_SLV])
   );

   for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
      localparam logic [AW-1:0] MY_BASE = SLV_BASE + AW'(i * NREG);
      crb_slave #(.REG_BITS(REG_BITS), .BASE(MY_BASE)) u_slv (
         .clk       (slv_clk[i]),
         .rst_n     (rst_n),
         .rd_stb    (rd_stb),
         .wr_stb    (wr_stb),
         .addr      (bus_addr),
         .wdata     (bus_wdata),
         .chain_in  (chain[i]),
         .chain_out (chain[i+1]),
         .ack       (ack_v[i])
      );
   end

   a_r4_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_v));
endmodule

// File: tb/sim_crb_bus.sv
module sim_crb_bus;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0;
   logic [2:0]  slv_clk;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, done, err;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #5  clk = ~clk;
   always #2  s0  = ~s0;
   always #13 s1  = ~s1;
   initial begin #3; forever #5 s2 = ~s2; end
   assign slv_clk = {s2, s1, s0};

   crb_bus u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .slv_clk   (slv_clk),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .rdata     (rdata)
   );

   // {write, addr, wdata_or_expected}
   localparam int NV = 12;
   localparam logic [42:0] VEC [NV] = '{
      {1'b1, 10'h040, 32'h1111_1111},
      {1'b1, 10'h045, 32'hA5A5_A5A5},
      {1'b1, 10'h04B, 32'hDEAD_BEEF},
      {1'b0, 10'h040, 32'h1111_1111},
      {1'b0, 10'h045, 32'hA5A5_A5A5},
      {1'b0, 10'h04B, 32'hDEAD_BEEF},
      {1'b0, 10'h041, 32'h0000_0000},
      {1'b1, 10'h041, 32'hFFFF_FFFF},
      {1'b0, 10'h041, 32'hFFFF_FFFF},
      {1'b0, 10'h040, 32'h1111_1111},
      {1'b0, 10'h049, 32'h0000_0000},
      {1'b0, 10'h044, 32'h0000_0000}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit w, input logic [9:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic e, output int cyc);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      rd = rdata;
      e  = err;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      logic        e;
      int          cyc;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(busy == 1'b0,  "R1 busy",  {31'd0, busy}, 32'd0);
      check(done == 1'b0,  "R1 done",  {31'd0, done}, 32'd0);
      check(err == 1'b0,   "R1 err",   {31'd0, err},  32'd0);
      check(rdata == '0,   "R1 rdata", rdata,         32'd0);
      xfer(1'b0, 10'h04A, '0, rd, e, cyc);
      check(rd == '0 && !e, "R1 register reads zero", rd, 32'd0);

      // Table walk: R2, R4, R9
      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i][42], VEC[i][41:32], VEC[i][31:0], rd, e, cyc);
         check(!e, "R2 no error", {31'd0, e}, 32'd0);
         check(cyc >= 2, "R7 min cycles", cyc, 32'd2);
         if (!VEC[i][42])
            check(rd == VEC[i][31:0], "R2/R4/R9 read data", rd, VEC[i][31:0]);
      end

      // R3: request while busy is ignored (slow slave keeps transfer long)
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h046; req_wdata = 32'h0000_1234;
      @(negedge clk);
      req_wdata = 32'h0000_9999; req_addr = 10'h047;
      check(busy == 1'b1, "R3 busy during transfer", {31'd0, busy}, 32'd1);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
      @(negedge clk);
      check(busy == 1'b0, "R3 no second transfer", {31'd0, busy}, 32'd0);
      xfer(1'b0, 10'h046, '0, rd, e, cyc);
      check(rd == 32'h0000_1234, "R3 first write kept", rd, 32'h0000_1234);
      xfer(1'b0, 10'h047, '0, rd, e, cyc);
      check(rd == 32'h0, "R3 ignored write absent", rd, 32'h0);

      // R6: unmapped write times out, no register changes
      xfer(1'b1, 10'h3FF, 32'h5555_5555, rd, e, cyc);
      check(e == 1'b1, "R6 timeout err", {31'd0, e}, 32'd1);
      check(cyc >= 256 && cyc <= 264, "R6 timeout length", cyc, 32'd256);
      check(rd == '0, "R6 rdata zero", rd, 32'd0);
      xfer(1'b0, 10'h040, '0, rd, e, cyc);
      check(rd == 32'h1111_1111 && !e, "R6 err cleared, data intact", rd, 32'h1111_1111);
      xfer(1'b0, 10'h000, '0, rd, e, cyc);
      check(e == 1'b1 && rd == '0, "R6 unmapped read", rd, 32'd0);

      finish_run();
   end
endmodule